// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block sits behind an analog-to-digital converter and inspects every finished conversion. Each result is compared against a programmable window bounded by a low and a high threshold. When a monitored result lands outside that window, a sticky out-of-window flag is set. An interrupt request follows the flag whenever the interrupt enable is on.

Monitoring has three modes: off, one selected channel, or every channel. The converter reports its current resolution with each result, as 12, 10, 8 or 6 bits. The result and both thresholds are left-aligned to 12 bits before they are compared, so one threshold format serves every resolution. Thresholds, mode and interrupt enable are set through a small write-only register port. The flag is cleared by writing a one to it.

Top module: `adc_window_watch`

## Requirements
- R1: After reset the flag and the interrupt are 0 and monitoring is off. The reset thresholds are low 0x000 and high 0xFFF.
- R2: When the enable bit is clear, no result sets the flag. The enable bit is bit 0 of the control register at address 0.
- R3: When the enable bit is set and the single-channel bit (bit 1 of address 0) is clear, an out-of-window result on any channel sets the flag. The flag is visible on the clock edge that samples the result.
- R4: When the enable and single-channel bits are both set, only results whose channel equals the 5-bit field at bits 12:8 of address 0 are compared. Results from any other channel leave the flag unchanged.
- R5: A result is out of window only when it is strictly above the high threshold or strictly below the low threshold. A result equal to either threshold is inside the window.
- R6: The resolution code is 2 bits: 00 means 12 bits, 01 means 10, 10 means 8 and 11 means 6. The result and both thresholds are each shifted left by twice the code and truncated to 12 bits before comparison. Result bits above the active resolution therefore have no effect.
- R7: Address 1 holds the thresholds: the high one in bits 27:16 and the low one in bits 11:0. All other bits are ignored.
- R8: The flag is sticky and stays set through later in-window results. Writing 1 to bit 0 of address 2 clears it on the next edge. Writing 0 there leaves it unchanged.
- R9: If a clear write and an out-of-window result arrive in the same cycle, the flag ends up set.
- R10: The interrupt equals the flag while the interrupt enable (bit 2 of address 0) is set, and is 0 while that bit is clear.
- R11: An out-of-window value on the result input has no effect while the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 thresholds, 2 flag clear) |
| wr_data | input | 32 | Register write data |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Right-aligned conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_mode | input | 2 | Resolution code of the result |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
The bench places results exactly on each threshold and one step past it. A design that used inclusive comparisons would flag the on-threshold values. At 6- and 10-bit resolution the bench applies results with stray upper bits set and thresholds near full scale. A design that skipped the alignment, or shifted only one side of the comparison, would flag wrongly or miss a real excursion. Single-channel mode is fed results from an unselected channel, and a clear is timed to coincide with an excursion. A design that lost the set-over-clear priority would drop that event.

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [MODE_W-1:0] res_mode,
  output logic              wd_flag,
  output logic              wd_irq
);
  localparam int HI_LSB = 16;
  localparam int SH_W   = MODE_W + 1;

  logic              cfg_en, cfg_single, cfg_ien;
  logic [CH_W-1:0]   cfg_chan;
  logic [DATA_W-1:0] thr_hi, thr_lo;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] res_al, hi_al, lo_al;
  logic              chan_ok, outside, hit, clr_wr;

  assign shamt   = {res_mode, 1'b0};
  assign res_al  = res_data << shamt;
  assign hi_al   = thr_hi << shamt;
  assign lo_al   = thr_lo << shamt;
  assign chan_ok = !cfg_single || (res_chan == cfg_chan);
  assign outside = (res_al > hi_al) || (res_al < lo_al);
  assign hit     = res_valid && cfg_en && chan_ok && outside;
  assign clr_wr  = wr_en && (wr_addr == 2'd2) && wr_data[0];
  assign wd_irq  = wd_flag && cfg_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_single <= 1'b0;
      cfg_ien    <= 1'b0;
      cfg_chan   <= '0;
      thr_hi     <= '1;
      thr_lo     <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd0) begin
        cfg_en     <= wr_data[0];
        cfg_single <= wr_data[1];
        cfg_ien    <= wr_data[2];
        cfg_chan   <= wr_data[8 +: CH_W];
      end else if (wr_addr == 2'd1) begin
        thr_hi <= wr_data[HI_LSB +: DATA_W];
        thr_lo <= wr_data[0 +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wd_flag <= 1'b0;
    else if (hit)    wd_flag <= 1'b1;
    else if (clr_wr) wd_flag <= 1'b0;
  end

  // R3
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wd_flag);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !clr_wr) |=> wd_flag);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !hit) |=> !wd_flag);
  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(res_valid && cfg_en));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> wd_flag);
endmodule

// File: tb/adc_window_watch_tb.sv
module adc_window_watch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic [1:0]  res_mode = '0;
  logic        wd_flag, wd_irq;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_window_watch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_mode(res_mode), .wd_flag(wd_flag), .wd_irq(wd_irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_thr(logic [11:0] hi, logic [11:0] lo);
    wr(2'd1, {4'hF, hi, 4'hF, lo});
  endtask

  task automatic conv(logic [4:0] ch, logic [11:0] d, logic [1:0] m);
    res_valid = 1'b1; res_chan = ch; res_data = d; res_mode = m;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic clear_flag();
    wr(2'd2, 32'h1);
  endtask

  task automatic t_reset();
    check("R1 flag", wd_flag, 1'b0);
    check("R1 irq", wd_irq, 1'b0);
    conv(5'd0, 12'hFFF, 2'd0);
    check("R1 disabled", wd_flag, 1'b0);
  endtask

  task automatic t_none();
    set_thr(12'h100, 12'h080);
    wr(2'd0, 32'h0);
    conv(5'd2, 12'hFFF, 2'd0);
    check("R2 off high", wd_flag, 1'b0);
    conv(5'd2, 12'h000, 2'd0);
    check("R2 off low", wd_flag, 1'b0);
  endtask

  task automatic t_all();
    wr(2'd0, 32'h1);
    conv(5'd7, 12'h080, 2'd0);
    check("R5 equal low", wd_flag, 1'b0);
    conv(5'd7, 12'h100, 2'd0);
    check("R5 equal high", wd_flag, 1'b0);
    conv(5'd7, 12'h101, 2'd0);
    check("R3 R7 above high", wd_flag, 1'b1);
    conv(5'd7, 12'h0C0, 2'd0);
    check("R8 sticky", wd_flag, 1'b1);
    clear_flag();
    check("R8 clear", wd_flag, 1'b0);
    conv(5'd19, 12'h07F, 2'd0);
    check("R3 R5 below low", wd_flag, 1'b1);
    wr(2'd2, 32'h0);
    check("R8 write zero", wd_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_single();
    wr(2'd0, 32'h0000_0303);
    conv(5'd4, 12'hFFF, 2'd0);
    check("R4 other channel", wd_flag, 1'b0);
    conv(5'd3, 12'hFFF, 2'd0);
    check("R4 selected channel", wd_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_res();
    wr(2'd0, 32'h1);
    set_thr(12'h030, 12'h010);
    conv(5'd1, 12'h031, 2'd3);
    check("R6 6b above", wd_flag, 1'b1);
    clear_flag();
    conv(5'd1, 12'h030, 2'd3);
    check("R6 6b equal", wd_flag, 1'b0);
    conv(5'd1, 12'h070, 2'd3);
    check("R6 6b upper bits ignored", wd_flag, 1'b0);
    conv(5'd1, 12'h00F, 2'd3);
    check("R6 6b below", wd_flag, 1'b1);
    clear_flag();
    conv(5'd1, 12'h02F, 2'd1);
    check("R6 10b inside", wd_flag, 1'b0);
    conv(5'd1, 12'hC2F, 2'd1);
    check("R6 10b upper bits ignored", wd_flag, 1'b0);
    conv(5'd1, 12'h031, 2'd0);
    check("R6 12b above", wd_flag, 1'b1);
    clear_flag();
    set_thr(12'h0FF, 12'h000);
    conv(5'd1, 12'h0FF, 2'd2);
    check("R6 8b full scale", wd_flag, 1'b0);
  endtask

  task automatic t_irq();
    set_thr(12'h100, 12'h080);
    wr(2'd0, 32'h1);
    conv(5'd0, 12'h200, 2'd0);
    check("R10 irq off", wd_irq, 1'b0);
    wr(2'd0, 32'h5);
    check("R10 irq on", wd_irq, 1'b1);
    clear_flag();
    check("R10 irq follows clear", wd_irq, 1'b0);
  endtask

  task automatic t_collide();
    res_valid = 1'b1; res_chan = 5'd0; res_data = 12'h200; res_mode = 2'd0;
    wr(2'd2, 32'h1);
    res_valid = 1'b0;
    check("R9 set wins", wd_flag, 1'b1);
    res_valid = 1'b1; res_data = 12'h0C0;
    wr(2'd2, 32'h1);
    res_valid = 1'b0;
    check("R8 clear with in-window", wd_flag, 1'b0);
  endtask

  task automatic t_novalid();
    res_valid = 1'b0; res_data = 12'hFFF; res_chan = 5'd0;
    tick(); tick();
    check("R11 strobe low", wd_flag, 1'b0);
  endtask

  initial begin
    #30000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_none();
    t_all();
    t_single();
    t_res();
    t_irq();
    t_collide();
    t_novalid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule